// File: doc/BRIEF.md
# VSB Receiver Acquisition Supervisor

This block supervises the bring-up of a VSB demodulator. It watches an analog lock indicator and the segment sync lock, and it samples the equalizer's 16-bit mean-square-error figure on every field sync strobe. From these inputs it walks a three-state machine: acquiring the channel, training the equalizer, and normal decoding. It drives the back-end decoders' reset, a one-symbol equalizer restart pulse and an equalizer-lock flag.

The back-end chain stays in reset through acquisition and training. After the machine reaches normal operation it releases that reset only at the next field boundary, so decoding starts on a whole field. In normal operation a timer watches for the sampled MSE staying above the programmed threshold. If the excess lasts longer than the timeout, the equalizer is pulsed into reset for one symbol and the machine goes back to training.

A small byte-wide read port gives access to the sampled MSE and to the lock flag. Reading the high byte also captures the low byte, so a read pair always describes one sample.

Top module: `vsb_acq_supervisor`

## Requirements
- R1: While `rstN` is low and after its release, `stateOut` is 0, `backEndRst` is 1, `eqRst` is 0, `eqLocked` is 0 and `regData` is 0. The state codes are 0 for acquisition, 1 for training and 2 for normal operation. `stateOut` never shows 3.
- R2: In state 0, the state becomes 1 on the clock edge after `lockIn` and `segLock` are both high. With only one of them high, the state stays at 0.
- R3: From any state, `lockIn` low or `segLock` low makes the state 0 on the next clock edge. This takes priority over every other transition.
- R4: `mseIn` is sampled on each clock where `fieldStrobe` is high; after reset the sample holds 0xFFFF. In state 1, the machine moves to state 2 on the edge after a sample strictly below `mseThresh` is taken. A sample equal to the threshold keeps it in state 1.
- R5: `backEndRst` is high in states 0 and 1. In state 2 it stays high until the first `fieldStrobe` seen in state 2, and it goes low on the clock edge that samples that strobe.
- R6: `eqLocked` is high exactly when the state is 2. A read of address 0x03 returns `eqLocked` in bit 0, with bits 7:1 equal to 0.
- R7: In state 2, a sampled MSE strictly above `mseThresh` starts a count of consecutive clocks. When the excess lasts for `TIMEOUT_CYCLES`+1 clocks, the state becomes 1 on the following edge.
- R8: In state 2, an excess shorter than the timeout changes nothing: the state stays 2 and `eqRst` stays low. The count clears as soon as the sample is at or below the threshold. A sample equal to the threshold never counts as an excess.
- R9: After a timeout, `eqRst` rises on the next clock where `symEn` is high. It falls on the next `symEn` clock after that, so it is high for exactly one symbol period. `eqRst` changes only on clocks where `symEn` is high.
- R10: A read (`regRd` high) puts its byte on `regData` one clock later. Address 0x01 returns the current sample's bits 15:8 and, at the same moment, captures bits 7:0. Address 0x02 returns the captured low byte. Every other address returns 0 except 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| lockIn | input | 1 | Analog front-end lock indicator |
| segLock | input | 1 | Segment sync lock held |
| fieldStrobe | input | 1 | One-clock field sync strobe |
| symEn | input | 1 | Symbol-rate clock enable |
| mseIn | input | 16 | Equalizer MSE of the training sequence |
| mseThresh | input | 16 | Programmable MSE threshold |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 8 | Register read address |
| stateOut | output | 2 | Current state code |
| backEndRst | output | 1 | Reset for the trellis, de-interleaver and RS decoder chain |
| eqRst | output | 1 | One-symbol equalizer restart pulse |
| eqLocked | output | 1 | Equalizer lock indicator |
| regData | output | 8 | Read data, valid one clock after `regRd` |

## Verification
The hardest state to reach is the timeout. The machine must be in normal operation with the back-end released, and a sample above the threshold must then sit in place for more than the whole timeout. Nothing upsets the lock inputs during that time, and each field strobe replaces the sample.

The bench shortens the timeout to 40 clocks. It loads one excessive sample with a single field strobe, then counts clocks from the edge that took the sample. This confirms the state is still 2 one clock before the expiry and 1 right after it. Over the next symbols it counts the high cycles of `eqRst`, which must equal the 4-clock symbol period. A second run removes the excess after 20 clocks and shows that nothing happens.

// File: rtl/vsb_acq_pkg.sv
package vsb_acq_pkg;

  localparam int MSE_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_MSE_HI = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_MSE_LO = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h03;

  typedef enum logic [1:0] {
    ST_ACQUIRE = 2'd0,
    ST_TRAIN   = 2'd1,
    ST_NORMAL  = 2'd2
  } acqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic inNormal;
    logic eqRstReq;
    logic locked;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic mseBelow;
    logic timerExpired;
  } dpStatus_t;

endpackage

// File: rtl/vsb_acq_datapath.sv
module vsb_acq_datapath
  import vsb_acq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fieldStrobe,
  input  logic              symEn,
  input  logic [MSE_W-1:0]  mseIn,
  input  logic [MSE_W-1:0]  mseThresh,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         status,
  output logic              eqRst,
  output logic [BYTE_W-1:0] regData
);

  localparam int TIMER_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(TIMEOUT_CYCLES);

  logic [MSE_W-1:0]   mseSample;
  logic [BYTE_W-1:0]  loShadow;
  logic [TIMER_W-1:0] excessCnt;
  logic               mseExcess;
  logic               pulsePending;

  // MSE sample, refreshed once per field sync
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mseSample <= '1;
    end else if (fieldStrobe) begin
      mseSample <= mseIn;
    end
  end

  assign mseExcess       = (mseSample > mseThresh);
  assign status.mseBelow = (mseSample < mseThresh);

  // consecutive-excess timer, active only in normal operation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excessCnt <= '0;
    end else if (!ctl.inNormal || !mseExcess) begin
      excessCnt <= '0;
    end else if (excessCnt == TIMER_LAST) begin
      excessCnt <= '0;
    end else begin
      excessCnt <= excessCnt + 1'b1;
    end
  end

  assign status.timerExpired = ctl.inNormal && mseExcess && (excessCnt == TIMER_LAST);

  // one-symbol equalizer restart pulse, aligned to the symbol enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulsePending <= 1'b0;
      eqRst        <= 1'b0;
    end else begin
      if (ctl.eqRstReq) begin
        pulsePending <= 1'b1;
      end
      if (symEn) begin
        if (pulsePending) begin
          eqRst        <= 1'b1;
          pulsePending <= 1'b0;
        end else begin
          eqRst <= 1'b0;
        end
      end
    end
  end

  // byte-wide read port with coherent MSE pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regData  <= '0;
      loShadow <= '0;
    end else if (regRd) begin
      unique case (regAddr)
        ADDR_MSE_HI: begin
          regData  <= mseSample[MSE_W-1 -: BYTE_W];
          loShadow <= mseSample[BYTE_W-1:0];
        end
        ADDR_MSE_LO: regData <= loShadow;
        ADDR_STATUS: regData <= {{(BYTE_W-1){1'b0}}, ctl.locked};
        default:     regData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/vsb_acq_control.sv
module vsb_acq_control
  import vsb_acq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lockIn,
  input  logic       segLock,
  input  logic       fieldStrobe,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic [1:0] stateOut,
  output logic       backEndRst,
  output logic       eqLocked
);

  acqState_e curState, nextState;
  logic      lockOk;
  logic      beReleased;

  assign lockOk = lockIn && segLock;

  always_comb begin
    nextState = curState;
    if (!lockOk) begin
      nextState = ST_ACQUIRE;
    end else begin
      unique case (curState)
        ST_ACQUIRE: nextState = ST_TRAIN;
        ST_TRAIN:   if (status.mseBelow) nextState = ST_NORMAL;
        ST_NORMAL:  if (status.timerExpired) nextState = ST_TRAIN;
        default:    nextState = ST_ACQUIRE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_ACQUIRE;
    end else begin
      curState <= nextState;
    end
  end

  // back-end release waits for the first field boundary inside normal operation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beReleased <= 1'b0;
    end else if (curState != ST_NORMAL) begin
      beReleased <= 1'b0;
    end else if (fieldStrobe) begin
      beReleased <= 1'b1;
    end
  end

  assign ctl.inNormal = (curState == ST_NORMAL);
  assign ctl.eqRstReq = (curState == ST_NORMAL) && lockOk && status.timerExpired;
  assign ctl.locked   = (curState == ST_NORMAL);

  assign stateOut   = curState;
  assign backEndRst = (curState != ST_NORMAL) || !beReleased;
  assign eqLocked   = (curState == ST_NORMAL);

endmodule

// File: rtl/vsb_acq_supervisor.sv
module vsb_acq_supervisor
  import vsb_acq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lockIn,
  input  logic        segLock,
  input  logic        fieldStrobe,
  input  logic        symEn,
  input  logic [15:0] mseIn,
  input  logic [15:0] mseThresh,
  input  logic        regRd,
  input  logic [7:0]  regAddr,
  output logic [1:0]  stateOut,
  output logic        backEndRst,
  output logic        eqRst,
  output logic        eqLocked,
  output logic [7:0]  regData
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  vsb_acq_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lockIn      (lockIn),
    .segLock     (segLock),
    .fieldStrobe (fieldStrobe),
    .status      (status),
    .ctl         (ctl),
    .stateOut    (stateOut),
    .backEndRst  (backEndRst),
    .eqLocked    (eqLocked)
  );

  vsb_acq_datapath #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .fieldStrobe (fieldStrobe),
    .symEn       (symEn),
    .mseIn       (mseIn),
    .mseThresh   (mseThresh),
    .regRd       (regRd),
    .regAddr     (regAddr),
    .ctl         (ctl),
    .status      (status),
    .eqRst       (eqRst),
    .regData     (regData)
  );

endmodule

// File: rtl/vsb_acq_checker.sv
module vsb_acq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       lockIn,
  input logic       segLock,
  input logic       symEn,
  input logic [1:0] stateOut,
  input logic       backEndRst,
  input logic       eqRst,
  input logic       eqLocked
);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    stateOut != 2'd3);

  assert_acq_exit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd0 && lockIn && segLock) |=> stateOut == 2'd1);

  assert_lock_loss_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!lockIn || !segLock) |=> stateOut == 2'd0);

  assert_backend_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut != 2'd2) |-> backEndRst);

  assert_eqlock_state_R6: assert property (@(posedge clk) disable iff (!rstN)
    eqLocked == (stateOut == 2'd2));

  assert_eqrst_symbol_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(eqRst) |-> $past(symEn));

endmodule

bind vsb_acq_supervisor vsb_acq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lockIn     (lockIn),
  .segLock    (segLock),
  .symEn      (symEn),
  .stateOut   (stateOut),
  .backEndRst (backEndRst),
  .eqRst      (eqRst),
  .eqLocked   (eqLocked)
);

// File: tb/sim_vsb_acq_supervisor.sv
`timescale 1ns/1ps
module sim_vsb_acq_supervisor;

  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lockIn, segLock, fieldStrobe, symEn, regRd;
  logic [15:0] mseIn, mseThresh;
  logic [7:0]  regAddr;
  logic [1:0]  stateOut;
  logic        backEndRst, eqRst, eqLocked;
  logic [7:0]  regData;

  int total = 0;
  int bad   = 0;
  logic [1:0] symDiv = 2'd0;

  always #10 clk = ~clk;

  // symbol enable: one clock in four, driven away from the active edge
  always @(negedge clk) begin
    symDiv <= symDiv + 2'd1;
    symEn  <= (symDiv == 2'd3);
  end

  vsb_acq_supervisor #(.TIMEOUT_CYCLES(TMO)) u0 (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .segLock(segLock),
    .fieldStrobe(fieldStrobe), .symEn(symEn), .mseIn(mseIn),
    .mseThresh(mseThresh), .regRd(regRd), .regAddr(regAddr),
    .stateOut(stateOut), .backEndRst(backEndRst), .eqRst(eqRst),
    .eqLocked(eqLocked), .regData(regData)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [15:0] v);
    mseIn = v; fieldStrobe = 1'b1;
    tick();
    fieldStrobe = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    regAddr = a; regRd = 1'b1;
    tick();
    regRd = 1'b0;
    d = regData;
  endtask

  task automatic t_reset;
    chk("R1 state", 16'(stateOut), 16'd0);
    chk("R1 backEndRst", 16'(backEndRst), 16'd1);
    chk("R1 eqRst", 16'(eqRst), 16'd0);
    chk("R1 eqLocked", 16'(eqLocked), 16'd0);
    chk("R1 regData", 16'(regData), 16'd0);
  endtask

  task automatic t_acquire;
    lockIn = 1'b1; segLock = 1'b0;
    tick();
    chk("R2 needs both locks", 16'(stateOut), 16'd0);
    segLock = 1'b1;
    tick();
    chk("R2 to training", 16'(stateOut), 16'd1);
    chk("R5 held in training", 16'(backEndRst), 16'd1);
  endtask

  task automatic t_train;
    strobe(16'h0100);
    tick();
    chk("R4 equal stays training", 16'(stateOut), 16'd1);
    strobe(16'h00FF);
    chk("R4 one edge after sample", 16'(stateOut), 16'd1);
    tick();
    chk("R4 to normal", 16'(stateOut), 16'd2);
    chk("R6 eqLocked in normal", 16'(eqLocked), 16'd1);
    chk("R5 held until field", 16'(backEndRst), 16'd1);
    tick(3);
    chk("R5 still held", 16'(backEndRst), 16'd1);
  endtask

  task automatic t_release;
    logic [7:0] d;
    strobe(16'h0080);
    chk("R5 released on field", 16'(backEndRst), 16'd0);
    readReg(8'h03, d);
    chk("R6 status bit", 16'(d), 16'd1);
  endtask

  task automatic t_short;
    int seen = 0;
    strobe(16'h0300);
    tick(19);
    strobe(16'h0050);
    for (int i = 0; i < 3*TMO; i++) begin
      if (eqRst) seen++;
      tick();
    end
    chk("R8 short excess state", 16'(stateOut), 16'd2);
    chk("R8 short excess eqRst", 16'(seen), 16'd0);
    strobe(16'h0100);
    for (int i = 0; i < 3*TMO; i++) begin
      if (eqRst) seen++;
      tick();
    end
    chk("R8 equal not excess", 16'(stateOut), 16'd2);
    chk("R8 equal eqRst", 16'(seen), 16'd0);
  endtask

  task automatic t_timeout;
    int highs = 0;
    strobe(16'h1234);
    tick(TMO);
    chk("R7 before expiry", 16'(stateOut), 16'd2);
    tick();
    chk("R7 after expiry", 16'(stateOut), 16'd1);
    chk("R5 held after timeout", 16'(backEndRst), 16'd1);
    chk("R6 eqLocked drops", 16'(eqLocked), 16'd0);
    for (int i = 0; i < 20; i++) begin
      if (eqRst) highs++;
      tick();
    end
    chk("R9 pulse width", 16'(highs), 16'd4);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    readReg(8'h01, d);
    chk("R10 high byte", 16'(d), 16'h0012);
    strobe(16'hABCD);
    readReg(8'h02, d);
    chk("R10 coherent low byte", 16'(d), 16'h0034);
    readReg(8'h01, d);
    chk("R10 new high byte", 16'(d), 16'h00AB);
    readReg(8'h02, d);
    chk("R10 new low byte", 16'(d), 16'h00CD);
    readReg(8'h07, d);
    chk("R10 unused address", 16'(d), 16'h0000);
    chk("R4 above stays training", 16'(stateOut), 16'd1);
  endtask

  task automatic t_loss;
    strobe(16'h0010);
    tick();
    chk("R4 retrained", 16'(stateOut), 16'd2);
    segLock = 1'b0;
    tick();
    chk("R3 seg lock lost", 16'(stateOut), 16'd0);
    chk("R3 backend held", 16'(backEndRst), 16'd1);
    segLock = 1'b1;
    tick();
    chk("R2 reacquire", 16'(stateOut), 16'd1);
    lockIn = 1'b0;
    tick();
    chk("R3 lockIn low", 16'(stateOut), 16'd0);
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; lockIn = 1'b0; segLock = 1'b0; fieldStrobe = 1'b0;
    regRd = 1'b0; regAddr = 8'h00; mseIn = 16'h0000; mseThresh = 16'h0100;
    symEn = 1'b0;
    tick(3);
    t_reset();
    rstN = 1'b1;
    tick();
    t_reset();
    t_acquire();
    t_train();
    t_release();
    t_short();
    t_timeout();
    t_regs();
    t_loss();
    finishRun();
  end

endmodule